// File: doc/BRIEF.md
# Link Rate Step Sequencer

This block sits beside one serial link of a power-managed network and turns a requested bit-rate level into a safe sequence of supply and clock changes. The link offers six operating points, coded 0 to 5. A code selects both a supply level and a bit rate, from 5 Gb/s at 0.9 V (code 0) up to 10 Gb/s at 1.8 V (code 5). Each code step adds 1 Gb/s and 0.18 V. A rate policy elsewhere raises `req_valid` with a target code. The sequencer then moves the link by exactly one level toward that target.

Going up, the supply rises first. It is given a fixed settling time while the link keeps running, and only then does the clock speed up. Going down, the clock slows first and the supply drops afterwards. Each clock change makes the receiver's clock recovery relock. During that time `link_en` is held low, so that upstream logic stops sending flits. While a transition is under way `busy` is high and new requests are dropped, not queued. The policy must ask again once `busy` falls.

Top module: `link_rate_sequencer`

## Requirements
- R1: After reset, `volt_level` and `freq_level` both hold code 5 (10 Gb/s, 1.8 V), `link_en` is 1 and `busy` is 0. Whenever `busy` is 0, the two codes are equal and `link_en` is 1.
- R2: For an accepted upward step from code L, `volt_level` becomes L+1 in the cycle after acceptance. `freq_level` becomes L+1 exactly SETTLE_CYCLES (default 100) cycles later.
- R3: For an accepted downward step from code L, `freq_level` becomes L-1 in the cycle after acceptance. `volt_level` becomes L-1 exactly RELOCK_CYCLES (default 20) cycles later.
- R4: `link_en` is 0 for exactly RELOCK_CYCLES cycles, starting in the cycle in which `freq_level` takes its new value. It is 1 during every voltage settling period.
- R5: Each accepted request moves both codes by exactly one level toward the requested code, however far away that code is.
- R6: `busy` is 1 for SETTLE_CYCLES+RELOCK_CYCLES cycles from the cycle after acceptance. A request made while `busy` is 1 has no effect, neither during the transition nor after it.
- R7: A request whose code equals the current code, or whose code is 6 or 7, is ignored: the outputs stay unchanged and `busy` stays 0.
- R8: `freq_level` never exceeds `volt_level`.
- R9: A request is taken at the clock edge where `req_valid` is 1 and `busy` is 0. A request made in the first idle cycle after a transition is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Network clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for a new target level |
| req_level | input | LVL_W (3) | Target level code, 0 = 5 Gb/s, 5 = 10 Gb/s |
| volt_level | output | LVL_W (3) | Supply level code driven to the regulator |
| freq_level | output | LVL_W (3) | Bit-rate level code driven to the clock source |
| link_en | output | 1 | High when flits may be sent; low while the receiver relocks |
| busy | output | 1 | High while a transition is in progress |

## Verification
The assertions check on every cycle the ordering rules: the clock code never exceeds the supply code, each code moves by at most one level per change, and the gating window is exactly the relock length. They also check that the rising clock step comes exactly one settling time after the supply step, and the falling supply step exactly one relock time after the clock step. That requests made during a transition are dropped for good, that equal or out-of-range codes do nothing, and that a far target still produces a single step can only be shown by the bench's scenarios. These compare the full cycle-by-cycle output trace against an independently computed schedule.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_SETTLE,
    ST_UP_RELOCK,
    ST_DN_RELOCK,
    ST_DN_SETTLE
  } lrs_state_e;

  // One level from cur toward tgt; unchanged when equal.
  function automatic int unsigned lrs_step_toward(int unsigned cur, int unsigned tgt);
    if (tgt > cur) return cur + 1;
    else if (tgt < cur) return cur - 1;
    else return cur;
  endfunction

  // Counter width able to hold the longer delay minus one.
  function automatic int lrs_cnt_width(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  function automatic int lrs_lvl_width(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lrs_step_planner.sv
module lrs_step_planner #(
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 3
) (
  input  logic             idle,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic [LVL_W-1:0] cur_level,
  output logic             accept,
  output logic             go_up,
  output logic [LVL_W-1:0] next_level
);
  import lrs_pkg::*;

  logic [31:0] cur_w;
  logic [31:0] req_w;
  logic        in_range;

  assign cur_w      = 32'(cur_level);
  assign req_w      = 32'(req_level);
  assign in_range   = req_w < 32'(NUM_LEVELS);
  assign accept     = idle && req_valid && in_range && (req_w != cur_w);
  assign go_up      = req_w > cur_w;
  assign next_level = LVL_W'(lrs_step_toward(cur_w, req_w));

endmodule

// File: rtl/lrs_delay_timer.sv
module lrs_delay_timer #(
  parameter int SETTLE_CYCLES = 100,
  parameter int RELOCK_CYCLES = 20,
  parameter int CNT_W         = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_settle,
  output logic done
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RELOCK_LAST = CNT_W'(RELOCK_CYCLES - 1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  assign done = running && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= sel_settle ? SETTLE_LAST : RELOCK_LAST;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/lrs_seq_fsm.sv
module lrs_seq_fsm #(
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             go_up,
  input  logic [LVL_W-1:0] next_level,
  input  logic             timer_done,
  output logic             timer_start,
  output logic             timer_sel_settle,
  output logic [LVL_W-1:0] volt_level,
  output logic [LVL_W-1:0] freq_level,
  output logic             link_en,
  output logic             busy,
  output logic             idle,
  output logic             volt_step,
  output logic             freq_step,
  output logic             freq_raise,
  output logic             volt_lower
);
  import lrs_pkg::*;

  localparam logic [LVL_W-1:0] TOP_LEVEL = LVL_W'(NUM_LEVELS - 1);

  lrs_state_e       state_q, state_d;
  logic [LVL_W-1:0] tgt_q, tgt_d;
  logic [LVL_W-1:0] volt_q, volt_d;
  logic [LVL_W-1:0] freq_q, freq_d;
  logic             link_q, link_d;

  always_comb begin
    state_d          = state_q;
    tgt_d            = tgt_q;
    volt_d           = volt_q;
    freq_d           = freq_q;
    link_d           = link_q;
    timer_start      = 1'b0;
    timer_sel_settle = 1'b0;
    volt_step        = 1'b0;
    freq_step        = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tgt_d       = next_level;
          timer_start = 1'b1;
          if (go_up) begin
            volt_d           = next_level;
            volt_step        = 1'b1;
            timer_sel_settle = 1'b1;
            state_d          = ST_UP_SETTLE;
          end else begin
            freq_d    = next_level;
            freq_step = 1'b1;
            link_d    = 1'b0;
            state_d   = ST_DN_RELOCK;
          end
        end
      end
      ST_UP_SETTLE: begin
        if (timer_done) begin
          freq_d      = tgt_q;
          freq_step   = 1'b1;
          link_d      = 1'b0;
          timer_start = 1'b1;
          state_d     = ST_UP_RELOCK;
        end
      end
      ST_UP_RELOCK: begin
        if (timer_done) begin
          link_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_DN_RELOCK: begin
        if (timer_done) begin
          link_d           = 1'b1;
          volt_d           = tgt_q;
          volt_step        = 1'b1;
          timer_start      = 1'b1;
          timer_sel_settle = 1'b1;
          state_d          = ST_DN_SETTLE;
        end
      end
      ST_DN_SETTLE: begin
        if (timer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= TOP_LEVEL;
      volt_q  <= TOP_LEVEL;
      freq_q  <= TOP_LEVEL;
      link_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      volt_q  <= volt_d;
      freq_q  <= freq_d;
      link_q  <= link_d;
    end
  end

  assign volt_level = volt_q;
  assign freq_level = freq_q;
  assign link_en    = link_q;
  assign idle       = (state_q == ST_IDLE);
  assign busy       = !idle;
  assign freq_raise = freq_step && (state_q == ST_UP_SETTLE);
  assign volt_lower = volt_step && (state_q == ST_DN_RELOCK);

endmodule

// File: rtl/link_rate_sequencer.sv
module link_rate_sequencer #(
  parameter int NUM_LEVELS    = 6,
  parameter int SETTLE_CYCLES = 100,
  parameter int RELOCK_CYCLES = 20,
  parameter int LVL_W         = lrs_pkg::lrs_lvl_width(NUM_LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  output logic [LVL_W-1:0] volt_level,
  output logic [LVL_W-1:0] freq_level,
  output logic             link_en,
  output logic             busy
);
  localparam int CNT_W = lrs_pkg::lrs_cnt_width(SETTLE_CYCLES, RELOCK_CYCLES);

  logic             accept;
  logic             go_up;
  logic [LVL_W-1:0] next_level;
  logic             idle;
  logic             timer_start;
  logic             timer_sel_settle;
  logic             timer_done;
  logic             volt_step;
  logic             freq_step;
  logic             freq_raise;
  logic             volt_lower;

  lrs_step_planner #(
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W)
  ) u_planner (
    .idle      (idle),
    .req_valid (req_valid),
    .req_level (req_level),
    .cur_level (volt_level),
    .accept    (accept),
    .go_up     (go_up),
    .next_level(next_level)
  );

  lrs_delay_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .RELOCK_CYCLES(RELOCK_CYCLES),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (timer_start),
    .sel_settle(timer_sel_settle),
    .done      (timer_done)
  );

  lrs_seq_fsm #(
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .accept          (accept),
    .go_up           (go_up),
    .next_level      (next_level),
    .timer_done      (timer_done),
    .timer_start     (timer_start),
    .timer_sel_settle(timer_sel_settle),
    .volt_level      (volt_level),
    .freq_level      (freq_level),
    .link_en         (link_en),
    .busy            (busy),
    .idle            (idle),
    .volt_step       (volt_step),
    .freq_step       (freq_step),
    .freq_raise      (freq_raise),
    .volt_lower      (volt_lower)
  );

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int NUM_LEVELS    = 6,
  parameter int SETTLE_CYCLES = 100,
  parameter int RELOCK_CYCLES = 20,
  parameter int LVL_W         = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] volt_level,
  input logic [LVL_W-1:0] freq_level,
  input logic             link_en,
  input logic             busy,
  input logic             volt_step,
  input logic             freq_step,
  input logic             freq_raise,
  input logic             volt_lower
);
  localparam int SAT = 1000000;

  int low_run;
  int since_v;
  int since_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= 0;
      since_v <= SAT;
      since_f <= SAT;
    end else begin
      low_run <= link_en ? 0 : ((low_run < SAT) ? low_run + 1 : low_run);
      since_v <= volt_step ? 0 : ((since_v < SAT) ? since_v + 1 : since_v);
      since_f <= freq_step ? 0 : ((since_f < SAT) ? since_f + 1 : since_f);
    end
  end

  a_r1_idle_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (volt_level == freq_level) && link_en);

  a_r2_settle_then_freq: assert property (@(posedge clk) disable iff (!rst_n)
    freq_raise |-> since_v == SETTLE_CYCLES - 1);

  a_r3_relock_then_volt: assert property (@(posedge clk) disable iff (!rst_n)
    volt_lower |-> since_f == RELOCK_CYCLES - 1);

  a_r4_relock_window: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !$past(link_en)) |-> low_run == RELOCK_CYCLES);

  a_r4_gate_on_freq: assert property (@(posedge clk) disable iff (!rst_n)
    freq_step |=> !link_en);

  a_r5_volt_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_level == $past(volt_level)) ||
    (volt_level == $past(volt_level) + 1'b1) ||
    ($past(volt_level) == volt_level + 1'b1));

  a_r5_freq_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_level == $past(freq_level)) ||
    (freq_level == $past(freq_level) + 1'b1) ||
    ($past(freq_level) == freq_level + 1'b1));

  a_r6_gate_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |-> busy);

  a_r6_volt_moves_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_level != $past(volt_level)) |-> busy);

  a_r8_freq_within_volt: assert property (@(posedge clk) disable iff (!rst_n)
    freq_level <= volt_level);

  a_r8_levels_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(volt_level) < 32'(NUM_LEVELS));

endmodule

bind link_rate_sequencer lrs_checker #(
  .NUM_LEVELS   (NUM_LEVELS),
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .RELOCK_CYCLES(RELOCK_CYCLES),
  .LVL_W        (LVL_W)
) u_lrs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .volt_level(volt_level),
  .freq_level(freq_level),
  .link_en   (link_en),
  .busy      (busy),
  .volt_step (volt_step),
  .freq_step (freq_step),
  .freq_raise(freq_raise),
  .volt_lower(volt_lower)
);

// File: tb/link_rate_sequencer_test.sv
`timescale 1ns/1ps
module link_rate_sequencer_test;
  localparam int LEVELS = 6;
  localparam int SET_C  = 100;
  localparam int REL_C  = 20;
  localparam int TOP    = LEVELS - 1;

  typedef struct {
    int    cyc;
    int    v;
    int    f;
    bit    le;
    bit    bz;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_level = 3'd0;
  logic [2:0] volt_level;
  logic [2:0] freq_level;
  logic       link_en;
  logic       busy;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   model = TOP;
  int   done_cyc = 0;
  bit   finished = 1'b0;
  exp_t sb[$];

  link_rate_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .volt_level(volt_level), .freq_level(freq_level), .link_en(link_en), .busy(busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int c, int v, int f, bit le, bit bz, string tag);
    exp_t e;
    e.cyc = c; e.v = v; e.f = f; e.le = le; e.bz = bz; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pop and compare expectations scheduled for the current cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.cyc < cyc) begin
        fails++;
        $display("FAIL %s: expectation for cycle %0d missed (actual cycle %0d, expected %0d)",
                 e.tag, e.cyc, cyc, e.cyc);
      end else if (int'(volt_level) != e.v || int'(freq_level) != e.f ||
                   link_en != e.le || busy != e.bz || freq_level > volt_level) begin
        fails++;
        $display("FAIL %s cyc %0d: actual v=%0d f=%0d le=%0b busy=%0b expected v=%0d f=%0d le=%0b busy=%0b",
                 e.tag, cyc, volt_level, freq_level, link_en, busy, e.v, e.f, e.le, e.bz);
      end
    end
  end

  task automatic push_idle(int n, string tag);
    for (int i = 1; i <= n; i++) push(cyc + i, model, model, 1'b1, 1'b0, tag);
    done_cyc = cyc + n;
  endtask

  // Driver: issue one request and schedule the whole expected trace.
  task automatic start_req(int lvl, string tag);
    int c;
    int n;
    c = cyc;
    req_valid = 1'b1;
    req_level = 3'(lvl);
    if (lvl < LEVELS && lvl != model) begin
      n = (lvl > model) ? model + 1 : model - 1;
      if (n > model) begin
        for (int i = 1; i <= SET_C; i++) push(c + i, n, model, 1'b1, 1'b1, {tag, " R2 up settle"});
        for (int i = 1; i <= REL_C; i++) push(c + SET_C + i, n, n, 1'b0, 1'b1, {tag, " R4 up relock"});
      end else begin
        for (int i = 1; i <= REL_C; i++) push(c + i, model, n, 1'b0, 1'b1, {tag, " R3 dn relock"});
        for (int i = 1; i <= SET_C; i++) push(c + REL_C + i, n, n, 1'b1, 1'b1, {tag, " R4 dn settle"});
      end
      model = n;
      done_cyc = c + SET_C + REL_C + 1;
      push(done_cyc, model, model, 1'b1, 1'b0, {tag, " R6 R9 idle again"});
    end else begin
      for (int i = 1; i <= 3; i++) push(c + i, model, model, 1'b1, 1'b0, {tag, " R7 ignored"});
      done_cyc = c + 3;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (cyc < done_cyc) @(negedge clk);
  endtask

  task automatic pulse_req(int lvl);
    req_valid = 1'b1;
    req_level = 3'(lvl);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R9: actual cycle %0d, expected completion before it", cyc);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_idle(4, "R1 reset state");
    wait_done();

    start_req(TOP, "R7 equal code");     wait_done();
    start_req(7,   "R7 code seven");     wait_done();
    start_req(6,   "R7 code six");       wait_done();

    // Far target: single step each time (R5, R3, R4).
    start_req(0, "R5 far down");         wait_done();
    for (int k = 0; k < 4; k++) begin
      start_req(0, "R3 down step");      wait_done();
    end
    start_req(0, "R7 at bottom");        wait_done();

    // Upward step with requests arriving while busy (R6).
    start_req(TOP, "R5 far up");
    repeat (4) @(negedge clk);
    pulse_req(0);
    while (cyc < done_cyc - REL_C + 4) @(negedge clk);
    pulse_req(TOP);
    wait_done();
    push_idle(4, "R6 busy request dropped");
    wait_done();

    // Back-to-back requests in the first idle cycle (R9).
    for (int k = 0; k < 4; k++) begin
      start_req(TOP, "R9 back to back up");
      wait_done();
    end
    start_req(2, "R8 step down from top");
    wait_done();
    push_idle(2, "R1 final idle");
    wait_done();
    repeat (2) @(negedge clk);

    if (sb.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL R1 scoreboard: actual %0d pending, expected 0", sb.size());
    end
    report();
  end

endmodule